// File: doc/BRIEF.md
# Nested Prioritized Interrupt Arbiter

This block decides when an interrupt may take the processor away from the code it is running. It has eight levels, numbered 0 to 7. A higher number means higher rank, so a level can preempt the handler of any lower level and handlers nest. The processor runs either a foreground (high-priority) process or a background (low-priority) process. Every level outranks the background process. A per-level band bit decides whether the level also outranks the foreground process.

The block records a request when that request rises, and it keeps a bitmap of the handlers that are in progress. Each cycle it compares the highest pending level with the current context. If the processor is inside a handler, the context is the top in-service level. Otherwise it is the rank of the running process. When the pending level wins, the block raises a preempt request and reports the level number. An acknowledge moves that level from pending to in-service. An end-of-handler pulse retires the innermost handler and restores the previous context.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset, pend_o and insvc_o are all zero and preempt_o is low.
- R2: A 0-to-1 transition of req_i[n] sets pend_o[n] at the next clock edge. A request held high sets it only once, so after an acknowledge it does not set it again until it has dropped and risen again.
- R3: Whenever pend_o is nonzero, win_lvl_o gives the index of its highest set bit.
- R4: When no level is in service and ctx_hi_i is 0 (background process running), any pending level raises preempt_o.
- R5: When no level is in service, ctx_hi_i is 1 and the configuration is valid, preempt_o is raised only if band_i[win_lvl_o] is 0. A band bit of 0 means the level ranks above the foreground process; 1 means it ranks below it.
- R6: When any level is in service, preempt_o is raised only if win_lvl_o is greater than the highest in-service level. ctx_hi_i and band_i have no effect in this case.
- R7: ack_i with ack_lvl_i = n, when pend_o[n] is set, clears pend_o[n] and sets insvc_o[n] at the next edge. An acknowledge of a level that is not pending changes neither bitmap.
- R8: eoh_i clears only the highest set bit of insvc_o at the next edge. With insvc_o at zero it has no effect. Without ack_i or eoh_i, insvc_o holds its value.
- R9: cfg_err_o is 1 exactly when some band bit at 0 lies below a band bit at 1. The valid patterns are 2^k-1 for k from 0 to 8.
- R10: While cfg_err_o is 1, the band bits are ignored and every level ranks above both processes, so with no level in service any pending level raises preempt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Level request lines, edge-detected |
| band_i | input | 8 | Per-level band bit: 0 ranks above the foreground process, 1 ranks below it |
| ctx_hi_i | input | 1 | 1 while the foreground process runs, 0 while the background process runs |
| ack_i | input | 1 | Acknowledge strobe for the level on ack_lvl_i |
| ack_lvl_i | input | 3 | Level being acknowledged |
| eoh_i | input | 1 | End-of-handler strobe |
| preempt_o | output | 1 | Preempt request |
| win_lvl_o | output | 3 | Highest pending level |
| cfg_err_o | output | 1 | Band bits are not contiguous from level 7 downward |
| pend_o | output | 8 | Pending bitmap |
| insvc_o | output | 8 | In-service bitmap |

## Verification
The hardest states to reach are deep nestings in which the pending and in-service bitmaps interleave. Reaching them takes a sequence of request edges and acknowledges, and no single input sets them. The bench raises every nonzero request pattern at once. It then acknowledges the levels from the lowest upward, so each acknowledge leaves higher pending levels above a growing in-service stack. After that it unwinds the stack one end-of-handler pulse at a time. A sweep over every ordered pair of levels covers preemption of an active handler and its refusal.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  parameter int unsigned LVL_N = 8;
  localparam int unsigned LVL_W = $clog2(LVL_N);
  typedef logic [LVL_N-1:0] lvl_vec_t;
  typedef logic [LVL_W-1:0] lvl_idx_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_nest_pkg::*;
(
  input  lvl_vec_t vec_i,
  output logic     any_o,
  output lvl_idx_t idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = 0; i < LVL_N; i++) begin
      if (vec_i[i]) idx_o = LVL_W'(i);
    end
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_nest_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  lvl_vec_t req_i,
  input  lvl_vec_t clr_i,
  output lvl_vec_t pend_o
);
  lvl_vec_t req_q, rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_o <= '0;
    end else begin
      req_q  <= req_i;
      pend_o <= (pend_o & ~clr_i) | rise;
    end
  end

  // R2
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((pend_o & $past(rise)) == $past(rise)));
  // R2
  pend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(rise)) == '0));
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
  import irq_nest_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  lvl_vec_t push_i,
  input  logic     pop_i,
  output lvl_vec_t insvc_o,
  output logic     any_o,
  output lvl_idx_t top_o
);
  lvl_vec_t pop_mask;

  irq_prio_enc i_top_enc (.vec_i(insvc_o), .any_o(any_o), .idx_o(top_o));

  assign pop_mask = (pop_i && any_o) ? (lvl_vec_t'(1) << top_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) insvc_o <= '0;
    else         insvc_o <= (insvc_o & ~pop_mask) | push_i;
  end

  // R8
  svc_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && push_i == '0 && insvc_o != '0) |=>
      ($countones(insvc_o) == $countones($past(insvc_o)) - 1));
  // R8
  svc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop_i && push_i == '0) |=> $stable(insvc_o));
endmodule

// File: rtl/irq_arb_core.sv
module irq_arb_core
  import irq_nest_pkg::*;
(
  input  lvl_vec_t pend_i,
  input  logic     svc_any_i,
  input  lvl_idx_t svc_top_i,
  input  lvl_vec_t band_i,
  input  logic     ctx_hi_i,
  output logic     preempt_o,
  output lvl_idx_t win_lvl_o,
  output logic     cfg_err_o
);
  logic pend_any, above_hp, seen_zero;

  irq_prio_enc i_pend_enc (.vec_i(pend_i), .any_o(pend_any), .idx_o(win_lvl_o));

  // a 0 (above foreground) must never sit below a 1
  always_comb begin
    seen_zero = 1'b0;
    cfg_err_o = 1'b0;
    for (int i = 0; i < LVL_N; i++) begin
      if (band_i[i] && seen_zero) cfg_err_o = 1'b1;
      if (!band_i[i]) seen_zero = 1'b1;
    end
  end

  assign above_hp = cfg_err_o | ~band_i[win_lvl_o];

  always_comb begin
    if (!pend_any)      preempt_o = 1'b0;
    else if (svc_any_i) preempt_o = (win_lvl_o > svc_top_i);
    else if (ctx_hi_i)  preempt_o = above_hp;
    else                preempt_o = 1'b1;
  end
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_nest_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_N-1:0] req_i,
  input  logic [LVL_N-1:0] band_i,
  input  logic             ctx_hi_i,
  input  logic             ack_i,
  input  logic [LVL_W-1:0] ack_lvl_i,
  input  logic             eoh_i,
  output logic             preempt_o,
  output logic [LVL_W-1:0] win_lvl_o,
  output logic             cfg_err_o,
  output logic [LVL_N-1:0] pend_o,
  output logic [LVL_N-1:0] insvc_o
);
  lvl_vec_t ack_vec;
  logic     svc_any;
  lvl_idx_t svc_top;

  assign ack_vec = ack_i ? (pend_o & (lvl_vec_t'(1) << ack_lvl_i)) : '0;

  irq_pend_reg i_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .clr_i(ack_vec), .pend_o(pend_o)
  );

  irq_svc_stack i_svc (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(ack_vec), .pop_i(eoh_i),
    .insvc_o(insvc_o), .any_o(svc_any), .top_o(svc_top)
  );

  irq_arb_core i_core (
    .pend_i(pend_o), .svc_any_i(svc_any), .svc_top_i(svc_top), .band_i(band_i),
    .ctx_hi_i(ctx_hi_i), .preempt_o(preempt_o), .win_lvl_o(win_lvl_o),
    .cfg_err_o(cfg_err_o)
  );

  // R3
  win_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o != '0) |-> ((pend_o >> win_lvl_o) == lvl_vec_t'(1)));
  // R6
  nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preempt_o |-> ((insvc_o >> win_lvl_o) == '0));
  // R4
  lo_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctx_hi_i && insvc_o == '0 && pend_o != '0) |-> preempt_o);
  // R7
  ack_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_o[ack_lvl_i]) |=> insvc_o[$past(ack_lvl_i)]);
endmodule

// File: tb/test_irq_nest_arb.sv
`timescale 1ns/1ps
module test_irq_nest_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, band = '0;
  logic       ctx_hi = 1'b0, ack = 1'b0, eoh = 1'b0;
  logic [2:0] ack_lvl = '0;
  logic       preempt, cfg_err;
  logic [2:0] win;
  logic [7:0] pend, insvc;

  int checks = 0, errors = 0;
  logic [7:0] m_pend = '0, m_svc = '0, m_req = '0;

  always #2 clk = ~clk;

  irq_nest_arb i_irq_nest_arb (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .band_i(band), .ctx_hi_i(ctx_hi),
    .ack_i(ack), .ack_lvl_i(ack_lvl), .eoh_i(eoh), .preempt_o(preempt),
    .win_lvl_o(win), .cfg_err_o(cfg_err), .pend_o(pend), .insvc_o(insvc)
  );

  function automatic int msb(input logic [7:0] v);
    int r = -1;
    for (int i = 0; i < 8; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic cfg_bad(input logic [7:0] b);
    logic [8:0] w = {1'b0, b};
    return ((w & (w + 9'd1)) != 9'd0);
  endfunction

  function automatic logic exp_pre(input logic [7:0] p, input logic [7:0] s,
                                   input logic [7:0] b, input logic hi);
    int h = msb(p);
    if (p == 0) return 1'b0;
    if (s != 0) return h > msb(s);
    if (!hi || cfg_bad(b)) return 1'b1;
    return !b[h];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_state(input string tag);
    chk({tag, " pend"}, pend, m_pend);
    chk({tag, " insvc"}, insvc, m_svc);
    chk({tag, " preempt"}, preempt, exp_pre(m_pend, m_svc, band, ctx_hi));
    if (m_pend != 0) chk({tag, " win"}, win, msb(m_pend));
  endtask

  task automatic do_req(input logic [7:0] v);
    req = v;
    step();
    m_pend |= v & ~m_req;
    m_req = v;
  endtask

  task automatic do_ack(input int l);
    ack = 1'b1;
    ack_lvl = 3'(l);
    step();
    ack = 1'b0;
    if (m_pend[l]) begin
      m_pend[l] = 1'b0;
      m_svc[l] = 1'b1;
    end
  endtask

  task automatic do_eoh();
    eoh = 1'b1;
    step();
    eoh = 1'b0;
    if (m_svc != 0) m_svc[msb(m_svc)] = 1'b0;
  endtask

  initial begin
    #(150000 * 4);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 pend", pend, 0);
    chk("R1 insvc", insvc, 0);
    chk("R1 preempt", preempt, 0);
    rst_n = 1'b1;
    step();
    chk("R1 preempt after release", preempt, 0);

    // R9 every band pattern
    for (int b = 0; b < 256; b++) begin
      band = 8'(b);
      #0.1;
      chk("R9 cfg_err", cfg_err, cfg_bad(8'(b)));
    end
    @(negedge clk);

    // single level, every band and process context: R3 R4 R5 R10
    for (int l = 0; l < 8; l++) begin
      band = '0;
      ctx_hi = 1'b0;
      do_req(8'(1 << l));
      check_state("R2 rise");
      for (int b = 0; b < 256; b++) begin
        for (int h = 0; h < 2; h++) begin
          band = 8'(b);
          ctx_hi = h[0];
          #0.1;
          chk(h == 0 ? "R4 lo ctx" : (cfg_bad(8'(b)) ? "R10 cfg err" : "R5 hi ctx"),
              preempt, exp_pre(m_pend, m_svc, band, ctx_hi));
          chk("R3 win", win, l);
        end
      end
      @(negedge clk);
      band = '0;
      ctx_hi = 1'b0;
      do_ack(l);
      check_state("R7 ack");
      step();
      check_state("R2 held no retrigger");
      do_req('0);
      do_eoh();
      check_state("R8 pop");
      do_eoh();
      check_state("R8 pop empty");
    end

    // all request patterns, ascending acks then unwinding
    for (int p = 1; p < 256; p++) begin
      do_req(8'(p));
      check_state("R3 multi");
      if (p != 255) begin
        for (int l = 0; l < 8; l++) begin
          if (!p[l]) begin
            do_ack(l);
            check_state("R7 ack not pending");
            break;
          end
        end
      end
      do_req('0);
      for (int l = 0; l < 8; l++) begin
        if (p[l]) begin
          do_ack(l);
          check_state("R6 nested ack");
        end
      end
      while (m_svc != 0) begin
        do_eoh();
        check_state("R8 unwind");
      end
    end

    // every ordered pair: in-service a, new request b, foreground and band ignored
    ctx_hi = 1'b1;
    band = 8'hFF;
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        do_req(8'(1 << a));
        do_ack(a);
        do_req('0);
        do_req(8'(1 << b));
        check_state("R6 pair");
        chk("R6 pair preempt", preempt, b > a);
        do_ack(b);
        check_state("R7 pair ack");
        do_req('0);
        while (m_svc != 0) begin
          do_eoh();
          check_state("R8 pair unwind");
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule